// File: doc/BRIEF.md
# TDM Daisy-Chain Output Merger

This block builds the outgoing time-division-multiplexed serial stream for one converter in a chain of identical converters. Each frame starts with the device's own four ADC channel words. These are followed by the leading slots of the frame that arrives from the upstream neighbour on a separate serial input. Each device therefore pushes the data of every device further up the chain four slots down the frame. The last device in the chain delivers all the chained channels to the system controller on one line.

A frame has 16 slots, or 8 slots in short mode. Each slot is 32 bit clocks wide and is sent most significant bit first. A sample is 24 bits, left-aligned in its slot, with the low 8 bits zero. A one-bit-clock-wide frame sync pulse marks the start of slot 1. Inputs are sampled on the rising edge of the bit clock, and the serial output changes on the falling edge. The incoming upstream stream is passed through a fixed delay of four slot times. As a result, incoming slot k lands in outgoing slot k+4, and whatever would run past the end of the frame is overwritten by local data.

Top module: `tdm_chain_merger`

## Requirements
- R1: After reset and until the first frame sync pulse, `sdo` stays 0, whatever `sdi` carries.
- R2: Channel k of `adc_in` (bits [24k+23:24k]) is sent in output slot k+1 (k = 0..3). It is sent MSB first: the 24 sample bits come first, then 8 zero bits. Bit n of a frame (n = 0 is the first bit after the frame sync edge) is valid before the rising edge n+1 edges after the sync edge.
- R3: The ADC words are captured at the rising edge where frame sync is sampled high. Changes on `adc_in` at any other time do not alter the frame being sent.
- R4: In 16-slot mode (`short_mode` = 0), output slots 5 to 16 carry input slots 1 to 12 of the same frame, in order, bit for bit.
- R5: In 16-slot mode, upstream input slots 13 to 16 never reach the output. The next frame's slots 1 to 4 still carry only local samples.
- R6: In 8-slot mode (`short_mode` = 1), output slots 5 to 8 carry input slots 1 to 4. Input slots 5 to 8 are dropped, and the frame counter wraps after 8 slots.
- R7: In the first frame after the first frame sync following reset, all forwarded slots are sent as zero, whatever the upstream input carries.
- R8: When the upstream input is held at 0, as on the first device of a chain, every forwarded slot is zero.
- R9: A frame sync pulse restarts the frame at slot 1, bit 0, even if it arrives before the current frame has ended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bclk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fs | input | 1 | Frame sync pulse, one bit clock wide, marks the start of slot 1 |
| short_mode | input | 1 | 0 selects 16-slot frames, 1 selects 8-slot frames |
| sdi | input | 1 | Serial data from the upstream device |
| adc_in | input | LOCAL_CH x SAMPLE_W (4 x 24) | Parallel local ADC samples, channel 0 in the low bits |
| sdo | output | 1 | Merged serial data toward the downstream device |

## Verification
The rising edge that samples frame sync loads the ADC words. Frame bit n then appears on `sdo` at the falling edge that follows n further rising edges. The upstream bit sampled at a rising edge reappears on `sdo` exactly 128 bit clocks (four slots) later. The bench drives every input, and reads `sdo`, one time unit after each falling edge. The value it reads is therefore the bit for the next rising edge, and the input it drives is sampled at that same edge. Frame bit n and upstream bit n thus fall in the same bench period. The bench gathers the bits of each slot into a 32-bit word and compares it with a word computed from the requirements. It sweeps both frame lengths, a truncated frame, first frames after reset, and a silent upstream line.

// File: rtl/tdm_merge_pkg.sv
package tdm_merge_pkg;

   // Frame length selection as seen on the short_mode pin
   typedef enum logic {
      FRAME_LONG  = 1'b0,
      FRAME_SHORT = 1'b1
   } frame_len_e;

endpackage

// File: rtl/tdm_slot_timer.sv
module tdm_slot_timer
   import tdm_merge_pkg::*;
#(
   parameter int SLOT_W      = 32,
   parameter int SLOTS_LONG  = 16,
   parameter int SLOTS_SHORT = 8
) (
   input  logic                          bclk,
   input  logic                          rst_n,
   input  logic                          fs,
   input  frame_len_e                    frame_len,
   output logic [$clog2(SLOT_W)-1:0]     bit_idx,
   output logic [$clog2(SLOTS_LONG)-1:0] slot_idx,
   output logic                          active,
   output logic                          ready
);
   localparam int BIT_W  = $clog2(SLOT_W);
   localparam int SLOT_IW = $clog2(SLOTS_LONG);

   logic [SLOT_IW-1:0] last_slot;

   assign last_slot = (frame_len == FRAME_SHORT) ? SLOT_IW'(SLOTS_SHORT - 1)
                                                 : SLOT_IW'(SLOTS_LONG - 1);

   always_ff @(posedge bclk or negedge rst_n) begin
      if (!rst_n) begin
         bit_idx  <= '0;
         slot_idx <= '0;
         active   <= 1'b0;
         ready    <= 1'b0;
      end else if (fs) begin
         bit_idx  <= '0;
         slot_idx <= '0;
         active   <= 1'b1;
         ready    <= active;
      end else if (active) begin
         if (bit_idx == BIT_W'(SLOT_W - 1)) begin
            bit_idx  <= '0;
            slot_idx <= (slot_idx >= last_slot) ? '0 : slot_idx + 1'b1;
         end else begin
            bit_idx <= bit_idx + 1'b1;
         end
      end
   end

endmodule

// File: rtl/tdm_delay_line.sv
module tdm_delay_line #(
   parameter int DEPTH = 128
) (
   input  logic bclk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   generate
      if (DEPTH == 1) begin : g_single
         logic stage_q;
         always_ff @(posedge bclk or negedge rst_n) begin
            if (!rst_n) stage_q <= 1'b0;
            else        stage_q <= din;
         end
         assign dout = stage_q;
      end else begin : g_chain
         logic [DEPTH-1:0] shift_q;
         always_ff @(posedge bclk or negedge rst_n) begin
            if (!rst_n) shift_q <= '0;
            else        shift_q <= {shift_q[DEPTH-2:0], din};
         end
         assign dout = shift_q[DEPTH-1];
      end
   endgenerate

endmodule

// File: rtl/tdm_local_capture.sv
module tdm_local_capture #(
   parameter int SLOT_W   = 32,
   parameter int SAMPLE_W = 24,
   parameter int LOCAL_CH = 4
) (
   input  logic                               bclk,
   input  logic                               rst_n,
   input  logic                               fs,
   input  logic [LOCAL_CH-1:0][SAMPLE_W-1:0]  adc_in,
   input  logic [$clog2(LOCAL_CH)-1:0]        sel,
   input  logic [$clog2(SLOT_W)-1:0]          bit_idx,
   output logic                               bit_out,
   output logic [LOCAL_CH-1:0][SAMPLE_W-1:0]  cap_q
);
   localparam int BIT_W = $clog2(SLOT_W);
   localparam int PAD_W = SLOT_W - SAMPLE_W;

   logic [SLOT_W-1:0] word;
   logic [BIT_W-1:0]  rev_idx;

   for (genvar ch = 0; ch < LOCAL_CH; ch++) begin : g_cap
      always_ff @(posedge bclk or negedge rst_n) begin
         if (!rst_n)  cap_q[ch] <= '0;
         else if (fs) cap_q[ch] <= adc_in[ch];
      end
   end

   generate
      if (PAD_W == 0) begin : g_full
         assign word = cap_q[sel];
      end else begin : g_padded
         assign word = {cap_q[sel], {PAD_W{1'b0}}};
      end
   endgenerate

   assign rev_idx = BIT_W'(SLOT_W - 1) - bit_idx;
   assign bit_out = word[rev_idx];

endmodule

// File: rtl/tdm_chain_merger.sv
module tdm_chain_merger
   import tdm_merge_pkg::*;
#(
   parameter int SLOT_W      = 32,
   parameter int SAMPLE_W    = 24,
   parameter int LOCAL_CH    = 4,
   parameter int SLOTS_LONG  = 16,
   parameter int SLOTS_SHORT = 8
) (
   input  logic                              bclk,
   input  logic                              rst_n,
   input  logic                              fs,
   input  logic                              short_mode,
   input  logic                              sdi,
   input  logic [LOCAL_CH-1:0][SAMPLE_W-1:0] adc_in,
   output logic                              sdo
);
   localparam int BIT_W   = $clog2(SLOT_W);
   localparam int SLOT_IW = $clog2(SLOTS_LONG);
   localparam int CH_W    = $clog2(LOCAL_CH);
   localparam int DELAY   = LOCAL_CH * SLOT_W;

   // Elaboration-time parameter checks
   if (SAMPLE_W > SLOT_W) begin : g_bad_sample
      $error("tdm_chain_merger: sample wider than slot");
   end
   if ((1 << BIT_W) != SLOT_W) begin : g_bad_slot
      $error("tdm_chain_merger: slot width must be a power of two");
   end
   if (LOCAL_CH < 2 || (1 << CH_W) != LOCAL_CH) begin : g_bad_ch
      $error("tdm_chain_merger: local channel count must be a power of two, at least 2");
   end
   if (SLOTS_SHORT <= LOCAL_CH || SLOTS_LONG < SLOTS_SHORT) begin : g_bad_frame
      $error("tdm_chain_merger: frame lengths must exceed the local channel count");
   end
   if ((1 << SLOT_IW) != SLOTS_LONG) begin : g_bad_long
      $error("tdm_chain_merger: long frame slot count must be a power of two");
   end

   logic [BIT_W-1:0]                  bit_idx;
   logic [SLOT_IW-1:0]                slot_idx;
   logic                              active;
   logic                              ready;
   logic                              local_bit;
   logic                              fwd_bit;
   logic                              nxt_bit;
   logic [LOCAL_CH-1:0][SAMPLE_W-1:0] cap_q;

   tdm_slot_timer #(
      .SLOT_W      (SLOT_W),
      .SLOTS_LONG  (SLOTS_LONG),
      .SLOTS_SHORT (SLOTS_SHORT)
   ) u_timer (
      .bclk      (bclk),
      .rst_n     (rst_n),
      .fs        (fs),
      .frame_len (frame_len_e'(short_mode)),
      .bit_idx   (bit_idx),
      .slot_idx  (slot_idx),
      .active    (active),
      .ready     (ready)
   );

   tdm_delay_line #(
      .DEPTH (DELAY)
   ) u_delay (
      .bclk  (bclk),
      .rst_n (rst_n),
      .din   (sdi),
      .dout  (fwd_bit)
   );

   tdm_local_capture #(
      .SLOT_W   (SLOT_W),
      .SAMPLE_W (SAMPLE_W),
      .LOCAL_CH (LOCAL_CH)
   ) u_local (
      .bclk    (bclk),
      .rst_n   (rst_n),
      .fs      (fs),
      .adc_in  (adc_in),
      .sel     (slot_idx[CH_W-1:0]),
      .bit_idx (bit_idx),
      .bit_out (local_bit),
      .cap_q   (cap_q)
   );

   always_comb begin
      if (!active)                              nxt_bit = 1'b0;
      else if (slot_idx < SLOT_IW'(LOCAL_CH))   nxt_bit = local_bit;
      else                                      nxt_bit = ready & fwd_bit;
   end

   // Launch on the falling edge so the receiver's rising edge sees a settled bit
   always_ff @(negedge bclk or negedge rst_n) begin
      if (!rst_n) sdo <= 1'b0;
      else        sdo <= nxt_bit;
   end

endmodule

// File: rtl/tdm_chain_merger_chk.sv
module tdm_chain_merger_chk #(
   parameter int SLOT_W     = 32,
   parameter int SAMPLE_W   = 24,
   parameter int LOCAL_CH   = 4,
   parameter int SLOTS_LONG = 16
) (
   input logic                              bclk,
   input logic                              rst_n,
   input logic                              fs,
   input logic                              sdo,
   input logic [$clog2(SLOT_W)-1:0]         bit_idx,
   input logic [$clog2(SLOTS_LONG)-1:0]     slot_idx,
   input logic [LOCAL_CH-1:0][SAMPLE_W-1:0] cap_q
);
   logic       seen_q;
   logic [1:0] sync_cnt_q;

   always_ff @(posedge bclk or negedge rst_n) begin
      if (!rst_n) begin
         seen_q     <= 1'b0;
         sync_cnt_q <= '0;
      end else if (fs) begin
         seen_q <= 1'b1;
         if (sync_cnt_q != 2'd3) sync_cnt_q <= sync_cnt_q + 2'd1;
      end
   end

   assert_idle_low_R1: assert property (@(posedge bclk) disable iff (!rst_n)
      !seen_q |-> (sdo == 1'b0));

   assert_pad_zero_R2: assert property (@(posedge bclk) disable iff (!rst_n)
      (seen_q && int'(slot_idx) < LOCAL_CH && int'(bit_idx) >= SAMPLE_W) |-> (sdo == 1'b0));

   assert_capture_hold_R3: assert property (@(posedge bclk) disable iff (!rst_n)
      !fs |=> $stable(cap_q));

   assert_first_frame_zero_R7: assert property (@(posedge bclk) disable iff (!rst_n)
      (sync_cnt_q == 2'd1 && int'(slot_idx) >= LOCAL_CH) |-> (sdo == 1'b0));

   assert_realign_R9: assert property (@(posedge bclk) disable iff (!rst_n)
      fs |=> (slot_idx == '0 && bit_idx == '0));

endmodule

bind tdm_chain_merger tdm_chain_merger_chk #(
   .SLOT_W     (SLOT_W),
   .SAMPLE_W   (SAMPLE_W),
   .LOCAL_CH   (LOCAL_CH),
   .SLOTS_LONG (SLOTS_LONG)
) u_chk (
   .bclk     (bclk),
   .rst_n    (rst_n),
   .fs       (fs),
   .sdo      (sdo),
   .bit_idx  (bit_idx),
   .slot_idx (slot_idx),
   .cap_q    (cap_q)
);

// File: tb/tdm_chain_merger_bench.sv
module tdm_chain_merger_bench;
   localparam int CLK_PERIOD = 10;
   localparam int SW  = 32;
   localparam int AW  = 24;
   localparam int NCH = 4;
   localparam int WATCHDOG = 100000;

   logic                    bclk = 1'b0;
   logic                    rst_n = 1'b0;
   logic                    fs = 1'b0;
   logic                    short_mode = 1'b0;
   logic                    sdi = 1'b0;
   logic [NCH-1:0][AW-1:0]  adc = '0;
   logic                    sdo;
   logic                    up_on = 1'b1;
   int                      checks = 0;
   int                      errors = 0;
   int                      cyc = 0;

   always #(CLK_PERIOD/2) bclk = ~bclk;

   tdm_chain_merger u_tdm_chain_merger (
      .bclk       (bclk),
      .rst_n      (rst_n),
      .fs         (fs),
      .short_mode (short_mode),
      .sdi        (sdi),
      .adc_in     (adc),
      .sdo        (sdo)
   );

   function automatic logic [AW-1:0] adc_val(int f, int ch);
      return AW'(f * 32'h1F3A7 + ch * 32'h51C3 + 32'h800001);
   endfunction

   function automatic logic [31:0] up_word(int f, int s);
      return (32'(f + 1) * 32'h9E3779B1) ^ (32'(s) * 32'h01F03C05) ^ 32'h80000001;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   always @(posedge bclk) begin
      cyc++;
      if (cyc > WATCHDOG) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         summary();
         $finish;
      end
   end

   // One period before the frame: frame sync high, ADC words of frame f0 presented
   task automatic lead_in(input int f0);
      @(negedge bclk); #1;
      fs  = 1'b1;
      sdi = 1'b0;
      for (int ch = 0; ch < NCH; ch++) adc[ch] = adc_val(f0, ch);
   endtask

   // Runs cut bit periods of frame f; the last period raises frame sync for f+1
   task automatic run_frame(input int f, input int cut, input bit first,
                            input string loc_req, input string fwd_req);
      logic [31:0] obs [16];
      logic [31:0] exp;
      int nslots;
      nslots = short_mode ? 8 : 16;
      for (int s = 0; s < 16; s++) obs[s] = '0;
      for (int n = 0; n < cut; n++) begin
         @(negedge bclk); #1;
         obs[n / SW][SW - 1 - (n % SW)] = sdo;
         fs  = (n == cut - 1);
         sdi = up_on ? up_word(f, n / SW)[SW - 1 - (n % SW)] : 1'b0;
         for (int ch = 0; ch < NCH; ch++)
            adc[ch] = (n == cut - 1) ? adc_val(f + 1, ch) : (~adc_val(f, ch) ^ AW'(n));
      end
      for (int s = 0; s < nslots && (s + 1) * SW <= cut; s++) begin
         if (s < NCH) begin
            exp = {adc_val(f, s), 8'h00};
            check(loc_req, obs[s], exp);
         end else begin
            exp = (first || !up_on) ? 32'h0 : up_word(f, s - NCH);
            check(fwd_req, obs[s], exp);
         end
      end
   endtask

   initial begin
      logic bad;
      rst_n = 1'b0;
      repeat (4) @(negedge bclk);
      #1;
      check("R1 reset state", {31'h0, sdo}, 32'h0);
      rst_n = 1'b1;

      // R1: no frame sync yet, upstream busy, output must stay low
      sdi = 1'b1;
      bad = 1'b0;
      for (int i = 0; i < 40; i++) begin
         @(negedge bclk); #1;
         if (sdo !== 1'b0) bad = 1'b1;
         sdi = ~sdi;
      end
      check("R1 idle before sync", {31'h0, bad}, 32'h0);

      // 16-slot frames: first frame masked (R7), then forwarding (R4, R5)
      short_mode = 1'b0;
      lead_in(0);
      run_frame(0, 512, 1'b1, "R2 R3", "R7");
      run_frame(1, 512, 1'b0, "R2 R3 R5", "R4");
      run_frame(2, 512, 1'b0, "R5", "R4");
      run_frame(3, 512, 1'b0, "R5", "R4");

      // 8-slot frames (R6)
      short_mode = 1'b1;
      run_frame(4, 256, 1'b0, "R2 R6", "R6");
      run_frame(5, 256, 1'b0, "R6", "R6");
      run_frame(6, 256, 1'b0, "R6", "R6");

      // Early frame sync after 150 bits, then a full frame (R9)
      short_mode = 1'b0;
      run_frame(7, 150, 1'b0, "R9", "R9");
      run_frame(8, 512, 1'b0, "R9", "R9");

      // Head of chain: silent upstream after a fresh reset (R8, R7)
      @(negedge bclk); #1;
      fs    = 1'b0;
      rst_n = 1'b0;
      up_on = 1'b0;
      sdi   = 1'b0;
      repeat (3) @(negedge bclk);
      #1;
      rst_n = 1'b1;
      lead_in(20);
      run_frame(20, 512, 1'b1, "R2", "R8 R7");
      run_frame(21, 512, 1'b0, "R2", "R8");

      @(negedge bclk); #1;
      fs = 1'b0;
      summary();
      $finish;
   end

endmodule